// File: doc/BRIEF.md
# Parallel Prefix Adder

A purely combinational N-bit binary adder. It adds two N-bit operands and a one-bit carry-in, and returns an N-bit sum together with a carry-out. Each column first forms its own generate and propagate bits. The carry-in then enters as an extra column placed below bit 0. A tree of generate/propagate merge cells doubles the span of every group at each level. After log2(N) levels, every column holds the group generate that reaches from it down to the carry-in. Each sum bit is the column's half-sum XORed with the group generate of the column below it.

The width is a parameter and must be a power of two. The default is 32. The block has no clock and no state. It is meant to sit in a larger datapath wherever a short carry path is worth the extra merge cells.

Top module: `pfx_adder`

## Requirements
- R1: For every pair of operands and either carry-in, the concatenation {carry_out, sum} equals the unsigned value op_a + op_b + carry_in.
- R2: The carry-in acts as a column below bit 0, with generate equal to carry_in and propagate equal to 0. As a result, no final group that reaches down to it propagates, and the carry into bit 0 is carry_in.
- R3: Column i generates when op_a[i] AND op_b[i] is 1 and propagates when op_a[i] OR op_b[i] is 1. The carry into column i+1 matches g_i OR (p_i AND carry into column i).
- R4: The prefix network has log2(N) levels, and the group span doubles at each level. A carry that enters at carry_in reaches all N columns and the carry-out: all-ones plus zero plus carry-in 1 gives sum 0 and carry_out 1.
- R5: Sum bit i is op_a[i] XOR op_b[i] XOR (the group generate from column i-1 down to the carry-in). When every column has op_a[i] XOR op_b[i] = 1, carry_out equals carry_in and the sum is all ones XOR the replicated carry_in.
- R6: carry_out is the group generate spanning column N-1 down to the carry-in. All ones plus one (carry_in 0) gives sum 0 and carry_out 1.
- R7: Zero plus zero with carry_in 1 gives sum 1 and carry_out 0. Zero plus zero with carry_in 0 gives sum 0 and carry_out 0.
- R8: The WIDTH parameter accepts any power of two, and the arithmetic of R1 holds at widths other than the default (checked at WIDTH = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| carry_in | input | 1 | Carry entering below bit 0 |
| sum | output | WIDTH | Low WIDTH bits of op_a + op_b + carry_in |
| carry_out | output | 1 | Carry leaving column WIDTH-1 |

## Verification
Hand-worked table vectors come first. They include a subtraction done by adding a two's complement operand, a sign-boundary crossing and alternating bit patterns. Together they separate a correct carry network from one that drops a merge level or swaps the upper and lower group.

The directed vectors cover three operand kinds, and each one stresses a different path. Operands that make every column propagate test whether the carry-in can cross the whole tree. All-ones plus one tests the carry-out path. Zero plus zero tests whether the carry-in reaches bit 0 alone.

Random 32-bit operands and an exhaustive sweep of an 8-bit instance then catch any single wrong prefix link that the fixed patterns happen to miss.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    // Generate/propagate pair for a column or a group of columns.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge an upper group with the adjacent lower group.
    function automatic gp_t gp_merge(input gp_t upper, input gp_t lower);
        gp_t r;
        r.g = upper.g | (upper.p & lower.g);
        r.p = upper.p & lower.p;
        return r;
    endfunction

    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/pfx_col_gp.sv
module pfx_col_gp
    import pfx_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output gp_t  [WIDTH-1:0] raw_gp,
    output gp_t  [WIDTH-1:0] seed_gp,
    output logic [WIDTH-1:0] half_sum
);
    gp_t low_col;

    // The column below bit 0 carries the carry-in: it generates but never propagates.
    assign low_col.g = carry_in;
    assign low_col.p = 1'b0;

    for (genvar c = 0; c < WIDTH; c++) begin : g_col
        assign raw_gp[c].g = op_a[c] & op_b[c];
        assign raw_gp[c].p = op_a[c] | op_b[c];
        assign half_sum[c] = op_a[c] ^ op_b[c];
        if (c == 0) begin : g_fold
            assign seed_gp[c] = gp_merge(raw_gp[c], low_col);
        end else begin : g_pass
            assign seed_gp[c] = raw_gp[c];
        end
    end

    always_comb begin
        AST_SEED_NO_PROP: assert (!seed_gp[0].p) else $error("bit 0 group propagates past carry_in"); // R2
    end
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
    import pfx_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t [WIDTH-1:0] seed_gp,
    output gp_t [WIDTH-1:0] grp_gp
);
    localparam int LEVELS = $clog2(WIDTH);

    gp_t [WIDTH-1:0] stage [0:LEVELS];

    assign stage[0] = seed_gp;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        localparam int DIST = 1 << lv;
        for (genvar c = 0; c < WIDTH; c++) begin : g_cell
            if (c >= DIST) begin : g_merge
                assign stage[lv+1][c] = gp_merge(stage[lv][c], stage[lv][c-DIST]);
            end else begin : g_buf
                assign stage[lv+1][c] = stage[lv][c];
            end
        end
    end

    assign grp_gp = stage[LEVELS];

    always_comb begin
        for (int c = 0; c < WIDTH; c++) begin
            AST_GROUP_NO_PROP: assert (!grp_gp[c].p) else $error("group %0d propagates", c); // R2
        end
    end
endmodule

// File: rtl/pfx_sum.sv
module pfx_sum
    import pfx_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t  [WIDTH-1:0] raw_gp,
    input  logic [WIDTH-1:0] half_sum,
    input  gp_t  [WIDTH-1:0] grp_gp,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    logic [WIDTH:0] col_carry;

    assign col_carry[0] = carry_in;
    for (genvar c = 1; c <= WIDTH; c++) begin : g_carry
        assign col_carry[c] = grp_gp[c-1].g;
    end

    assign sum       = half_sum ^ col_carry[WIDTH-1:0];
    assign carry_out = col_carry[WIDTH];

    always_comb begin
        for (int c = 0; c < WIDTH; c++) begin
            AST_CARRY_RECUR: assert (col_carry[c+1] == (raw_gp[c].g | (raw_gp[c].p & col_carry[c])))
                else $error("carry recurrence broken at %0d", c); // R3
        end
    end
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
    import pfx_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    gp_t  [WIDTH-1:0] raw_gp;
    gp_t  [WIDTH-1:0] seed_gp;
    gp_t  [WIDTH-1:0] grp_gp;
    logic [WIDTH-1:0] half_sum;

    initial begin
        AST_WIDTH_POW2: assert (is_pow2(WIDTH)) else $error("WIDTH must be a power of two"); // R8
    end

    pfx_col_gp #(.WIDTH(WIDTH)) u_col (
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .raw_gp   (raw_gp),
        .seed_gp  (seed_gp),
        .half_sum (half_sum)
    );

    pfx_tree #(.WIDTH(WIDTH)) u_tree (
        .seed_gp (seed_gp),
        .grp_gp  (grp_gp)
    );

    pfx_sum #(.WIDTH(WIDTH)) u_sum (
        .raw_gp    (raw_gp),
        .half_sum  (half_sum),
        .grp_gp    (grp_gp),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );

    always_comb begin
        AST_SUM_MATCH: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("sum mismatch"); // R1
        AST_FULL_PROP: assert (!(&(op_a ^ op_b)) || (carry_out == carry_in))
            else $error("all-propagate carry mismatch"); // R5
        AST_ZERO_OPS: assert (!((op_a == '0) && (op_b == '0)) || (!carry_out && (sum == {{(WIDTH-1){1'b0}}, carry_in})))
            else $error("zero operands mismatch"); // R7
    end
endmodule

// File: tb/sim_pfx_adder.sv
module sim_pfx_adder;
    localparam int W  = 32;
    localparam int WS = 8;
    localparam int NT = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0]  a, b, s;
    logic          ci, co;
    logic [WS-1:0] as, bs, ss;
    logic          cis, cos;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    pfx_adder #(.WIDTH(W)) u0 (.op_a(a), .op_b(b), .carry_in(ci), .sum(s), .carry_out(co));
    pfx_adder #(.WIDTH(WS)) u1 (.op_a(as), .op_b(bs), .carry_in(cis), .sum(ss), .carry_out(cos));

    // Hand-worked vectors: a, b, cin, expected sum, expected carry-out.
    localparam logic [W-1:0] T_A [NT] = '{32'd2, 32'd25, 32'hFFFFFFFF, 32'd0, 32'h7FFFFFFF,
                                          32'hFFFFFFFF, 32'hAAAAAAAA, 32'h80000000, 32'h12345678, 32'hFFFF0000};
    localparam logic [W-1:0] T_B [NT] = '{32'd3, 32'hFFFFFFE0, 32'd1, 32'd0, 32'd1,
                                          32'hFFFFFFFF, 32'h55555555, 32'h80000000, 32'h0FEDCBA8, 32'h0000FFFF};
    localparam logic         T_C [NT] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [W-1:0] T_S [NT] = '{32'd5, 32'hFFFFFFF9, 32'd0, 32'd1, 32'h80000000,
                                          32'hFFFFFFFF, 32'd0, 32'd0, 32'h22222220, 32'hFFFFFFFF};
    localparam logic         T_O [NT] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

    task automatic check32(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply32(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic xc);
        @(negedge clk);
        a = xa; b = xb; ci = xc;
        #2;
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0; as = '0; bs = '0; cis = 1'b0;
        repeat (2) @(posedge clk);

        // Idle inputs: all zero gives a zero result (R7).
        apply32('0, '0, 1'b0);
        check32("R7 idle zero", {co, s}, '0);

        // Table walk (R1, R6 and sign-crossing cases).
        for (int i = 0; i < NT; i++) begin
            apply32(T_A[i], T_B[i], T_C[i]);
            check32("R1 table", {co, s}, {T_O[i], T_S[i]});
        end

        // R7: zero plus zero with carry-in set.
        apply32('0, '0, 1'b1);
        check32("R7 zero+zero+cin", {co, s}, {1'b0, 32'd1});

        // R6: all ones plus one.
        apply32('1, 32'd1, 1'b0);
        check32("R6 ones+1", {co, s}, {1'b1, 32'd0});

        // R4: carry-in crosses every column.
        apply32('1, '0, 1'b1);
        check32("R4 cin full travel", {co, s}, {1'b1, 32'd0});

        // R2: carry-in alone reaches bit 0.
        apply32(32'd4, 32'd8, 1'b1);
        check32("R2 cin into bit0", {co, s}, {1'b0, 32'd13});

        // R5: every column propagates; carry-out follows carry-in.
        apply32(32'hF0F0F0F0, 32'h0F0F0F0F, 1'b0);
        check32("R5 all-prop cin0", {co, s}, {1'b0, 32'hFFFFFFFF});
        apply32(32'h3C3C3C3C, 32'hC3C3C3C3, 1'b1);
        check32("R5 all-prop cin1", {co, s}, {1'b1, 32'h00000000});

        // R3: a column that generates with no incoming carry.
        apply32(32'h00010000, 32'h00010000, 1'b0);
        check32("R3 single generate", {co, s}, {1'b0, 32'h00020000});

        // R1: random operands against a behavioural sum.
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] ra, rb;
            logic         rc;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            apply32(ra, rb, rc);
            check32("R1 random", {co, s}, {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc});
        end

        // R8: exhaustive operands at WIDTH = 8.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [WS:0] exp8;
                @(negedge clk);
                as = 8'(x); bs = 8'(y); cis = 1'((x + y) >> 3);
                #2;
                exp8 = 9'(x) + 9'(y) + 9'(cis);
                checks++;
                if ({cos, ss} !== exp8) begin
                    errors++;
                    $display("FAIL R8 width8 %0d+%0d: got %h expected %h", x, y, {cos, ss}, exp8);
                end
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule